// File: doc/BRIEF.md
# Mode and Standby Pin Interpreter

This block turns one external multi-function control pin of a power-management controller into two kinds of decision. The first is a per-rail converter switching-mode select, where 1 means forced PWM and 0 means auto-PFM. The second is a standby-or-sleep request for the power-state sequencer. The pin passes through a synchronizer and a deglitch counter. A polarity bit then says which level counts as asserted. A 2-bit function select decides whether the pin drives the mode, the standby request, both, or neither. Register override bits can force PWM or force a standby request whatever the pin does.

Each rail's mode output is held while that rail reports a ramp in progress. The held rail picks up the pending value once its ramp ends. The request is held at zero, and the pin is treated as deasserted, until the device has first reached ACTIVE. While the device sits in SLEEP, the request is frozen. Request edges are turned into one-cycle entry and exit pulses. The SLEEP-or-STBY target is captured when a request starts.

Top module: `mfpin_ctrl`

## Requirements
- R1: The pin goes through a two-stage synchronizer. The filtered level takes a new value only after the synchronized level has differed from it for DG_CYCLES consecutive clocks (default 8). A shorter excursion changes no output.
- R2: With function select 2'b00 (mode only), each rail's target mode is reg_pwm_i OR pin-asserted. Pin-asserted means filtered high when pin_pol_i=0 and filtered low when pin_pol_i=1. A mode value of 1 means forced PWM.
- R3: With function select 2'b00, the pin never affects stby_req_o. The request follows reg_stby_i alone.
- R4: With function select 2'b01 (standby only), the request is reg_stby_i OR pin-standby. Pin-standby means filtered low when pin_pol_i=0 and filtered high when pin_pol_i=1. The mode is reg_pwm_i alone.
- R5: With function select 2'b10 (combined), the request is formed as in R4. The mode is reg_pwm_i OR NOT pin-standby.
- R6: Combined operation applies only when sleep_sel_i=0. With sleep_sel_i=1, select 2'b10 behaves as 2'b01. Select 2'b11 leaves the pin unused: mode is reg_pwm_i and the request is reg_stby_i.
- R7: While ramp_i[k]=1, pwm_o[k] holds its value and the other rails still update. One clock after ramp_i[k] clears, pwm_o[k] takes the pending value.
- R8: dev_state_i uses the codes 0 OFF, 1 INIT, 2 ACTIVE, 3 STBY and 4 SLEEP. Until the cycle after dev_state_i first equals 2, stby_req_o stays 0 and the pin counts as deasserted. After that, requests are honoured in any state and during ramps.
- R9: While dev_state_i equals 4 (SLEEP), stby_req_o keeps its value whatever the pin or the registers do.
- R10: stby_enter_o pulses for one clock when stby_req_o rises, and stby_exit_o pulses when it falls, both in the same clock as the request change. sleep_tgt_o captures sleep_select at each rise.
- R11: After reset, pwm_o is all ones, and stby_req_o, stby_enter_o, stby_exit_o and sleep_tgt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw multi-function pin level |
| pin_func_i | input | 2 | Pin function: 0 mode, 1 standby, 2 combined, 3 unused |
| pin_pol_i | input | 1 | Pin polarity select |
| sleep_sel_i | input | 1 | Request target: 0 STBY, 1 SLEEP |
| reg_pwm_i | input | 1 | Register override forcing PWM |
| reg_stby_i | input | 1 | Register standby request |
| ramp_i | input | N_RAILS | Per-rail ramp-in-progress flags |
| dev_state_i | input | 3 | Current device state code |
| pwm_o | output | N_RAILS | Per-rail mode, 1 = forced PWM |
| stby_req_o | output | 1 | Standby/sleep request level |
| sleep_tgt_o | output | 1 | Target captured at request start, 1 = SLEEP |
| stby_enter_o | output | 1 | One-cycle pulse on request rise |
| stby_exit_o | output | 1 | One-cycle pulse on request fall |

## Verification
The bench sweeps every polarity, pin level and override combination in each function select. Any swapped polarity term would show up as an inverted mode or request in half of those rows. It sends pin pulses just shorter and just longer than the deglitch window. A counter that did not restart, or that was off by one, would let a glitch through or ignore a valid change. It raises a single rail's ramp flag during a mode change: a rail that was not blanked would move early, and one that was never released would stay stale. It holds the pin asserted before the device is ACTIVE and toggles the pin while in SLEEP, where a missing gate or freeze would issue a request or drop one early.

// File: rtl/mfpin_pkg.sv
package mfpin_pkg;

   typedef enum logic [1:0] {
      PF_MODE = 2'd0,
      PF_STBY = 2'd1,
      PF_BOTH = 2'd2,
      PF_NONE = 2'd3
   } pin_func_e;

   typedef enum logic [2:0] {
      DS_OFF    = 3'd0,
      DS_INIT   = 3'd1,
      DS_ACTIVE = 3'd2,
      DS_STBY   = 3'd3,
      DS_SLEEP  = 3'd4
   } dev_state_e;

   typedef struct packed {
      logic pwm;
      logic req;
   } want_t;

endpackage

// File: rtl/mfpin_sync.sv
module mfpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("mfpin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b0;
            else         chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= 1'b0;
            else         chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mfpin_deglitch.sv
module mfpin_deglitch #(
   parameter int DG_CYCLES = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (DG_CYCLES < 0) begin : g_bad
      $error("mfpin_deglitch: DG_CYCLES must not be negative");
   end

   logic filt_q;

   if (DG_CYCLES == 0) begin : g_bypass
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) filt_q <= 1'b0;
         else         filt_q <= d_i;
      end
   end else begin : g_count
      localparam int CW = (DG_CYCLES > 1) ? $clog2(DG_CYCLES) : 1;
      localparam logic [CW-1:0] LAST = CW'(DG_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
         end else if (d_i != filt_q) begin
            if (cnt_q == LAST) begin
               filt_q <= d_i;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign q_o = filt_q;
endmodule

// File: rtl/mfpin_decode.sv
module mfpin_decode
   import mfpin_pkg::*;
(
   input  logic [1:0] pin_func_i,
   input  logic       pin_pol_i,
   input  logic       sleep_sel_i,
   input  logic       reg_pwm_i,
   input  logic       reg_stby_i,
   input  logic       level_i,
   input  logic       pin_ok_i,
   output want_t      want_o
);
   pin_func_e func;
   logic      mode_act;
   logic      stby_act;

   always_comb begin
      func = pin_func_e'(pin_func_i);
      if (func == PF_BOTH && sleep_sel_i) func = PF_STBY;
      mode_act = pin_ok_i & (level_i ^ pin_pol_i);
      stby_act = pin_ok_i & ~(level_i ^ pin_pol_i);
      unique case (func)
         PF_MODE: begin
            want_o.pwm = reg_pwm_i | mode_act;
            want_o.req = reg_stby_i;
         end
         PF_STBY: begin
            want_o.pwm = reg_pwm_i;
            want_o.req = reg_stby_i | stby_act;
         end
         PF_BOTH: begin
            want_o.pwm = reg_pwm_i | ~stby_act;
            want_o.req = reg_stby_i | stby_act;
         end
         default: begin
            want_o.pwm = reg_pwm_i;
            want_o.req = reg_stby_i;
         end
      endcase
   end
endmodule

// File: rtl/mfpin_rail_mode.sv
module mfpin_rail_mode #(
   parameter int N_RAILS = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               pwm_want_i,
   input  logic [N_RAILS-1:0] ramp_i,
   output logic [N_RAILS-1:0] pwm_o
);
   if (N_RAILS < 1) begin : g_bad
      $error("mfpin_rail_mode: N_RAILS must be at least 1");
   end

   for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        pwm_o[r] <= 1'b1;
         else if (!ramp_i[r]) pwm_o[r] <= pwm_want_i;
      end
   end
endmodule

// File: rtl/mfpin_ctrl.sv
module mfpin_ctrl
   import mfpin_pkg::*;
#(
   parameter int N_RAILS     = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DG_CYCLES   = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               pin_i,
   input  logic [1:0]         pin_func_i,
   input  logic               pin_pol_i,
   input  logic               sleep_sel_i,
   input  logic               reg_pwm_i,
   input  logic               reg_stby_i,
   input  logic [N_RAILS-1:0] ramp_i,
   input  logic [2:0]         dev_state_i,
   output logic [N_RAILS-1:0] pwm_o,
   output logic               stby_req_o,
   output logic               sleep_tgt_o,
   output logic               stby_enter_o,
   output logic               stby_exit_o
);
   logic  pin_sync;
   logic  pin_filt;
   logic  seen_active_q;
   logic  req_next;
   want_t want;

   mfpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   mfpin_deglitch #(.DG_CYCLES(DG_CYCLES)) u_dg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_sync),
      .q_o   (pin_filt)
   );

   mfpin_decode u_dec (
      .pin_func_i (pin_func_i),
      .pin_pol_i  (pin_pol_i),
      .sleep_sel_i(sleep_sel_i),
      .reg_pwm_i  (reg_pwm_i),
      .reg_stby_i (reg_stby_i),
      .level_i    (pin_filt),
      .pin_ok_i   (seen_active_q),
      .want_o     (want)
   );

   mfpin_rail_mode #(.N_RAILS(N_RAILS)) u_rail (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pwm_want_i(want.pwm),
      .ramp_i    (ramp_i),
      .pwm_o     (pwm_o)
   );

   always_comb begin
      if (dev_state_i == DS_SLEEP) req_next = stby_req_o;
      else                         req_next = want.req & seen_active_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_active_q <= 1'b0;
         stby_req_o    <= 1'b0;
         stby_enter_o  <= 1'b0;
         stby_exit_o   <= 1'b0;
         sleep_tgt_o   <= 1'b0;
      end else begin
         if (dev_state_i == DS_ACTIVE) seen_active_q <= 1'b1;
         stby_req_o   <= req_next;
         stby_enter_o <= req_next & ~stby_req_o;
         stby_exit_o  <= ~req_next & stby_req_o;
         if (req_next & ~stby_req_o) sleep_tgt_o <= sleep_sel_i;
      end
   end
endmodule

// File: rtl/mfpin_ctrl_chk.sv
module mfpin_ctrl_chk #(
   parameter int N_RAILS = 3
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [N_RAILS-1:0] ramp_i,
   input logic [2:0]         dev_state_i,
   input logic [N_RAILS-1:0] pwm_o,
   input logic               stby_req_o,
   input logic               stby_enter_o,
   input logic               stby_exit_o,
   input logic               seen_active
);
   for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
      AST_RAMP_HOLDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ramp_i[r] |=> pwm_o[r] == $past(pwm_o[r])); // R7
   end

   AST_NO_REQ_BEFORE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_active |-> !stby_req_o); // R8

   AST_SLEEP_FREEZES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(dev_state_i) == 3'd4 |-> $stable(stby_req_o)); // R9

   AST_ENTER_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stby_enter_o |-> $rose(stby_req_o)); // R10

   AST_EXIT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stby_exit_o |-> $fell(stby_req_o)); // R10

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({stby_enter_o, stby_exit_o})); // R10
endmodule

bind mfpin_ctrl mfpin_ctrl_chk #(.N_RAILS(N_RAILS)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ramp_i      (ramp_i),
   .dev_state_i (dev_state_i),
   .pwm_o       (pwm_o),
   .stby_req_o  (stby_req_o),
   .stby_enter_o(stby_enter_o),
   .stby_exit_o (stby_exit_o),
   .seen_active (seen_active_q)
);

// File: tb/mfpin_ctrl_test.sv
module mfpin_ctrl_test;
   localparam int NR     = 3;
   localparam int DG     = 8;
   localparam int SETTLE = DG + 6;
   localparam int WD_MAX = 50000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b0;
   logic [1:0]    func = 2'd1;
   logic          pol = 1'b0;
   logic          slp = 1'b0;
   logic          mreg = 1'b0;
   logic          sreg = 1'b0;
   logic [NR-1:0] ramp = '0;
   logic [2:0]    dev = 3'd1;
   logic [NR-1:0] pwm;
   logic          req, tgt, ent, ext;

   int    checks = 0;
   int    errors = 0;
   int    cycles = 0;
   string tag = "R11";

   always #2 clk = ~clk;

   mfpin_ctrl #(.N_RAILS(NR), .SYNC_STAGES(2), .DG_CYCLES(DG)) uut (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_func_i(func),
      .pin_pol_i(pol), .sleep_sel_i(slp), .reg_pwm_i(mreg), .reg_stby_i(sreg),
      .ramp_i(ramp), .dev_state_i(dev), .pwm_o(pwm), .stby_req_o(req),
      .sleep_tgt_o(tgt), .stby_enter_o(ent), .stby_exit_o(ext)
   );

   // Behavioural reference, advanced on every rising edge
   bit        sq[$];
   bit        m_filt, m_seen, m_req, m_ent, m_ext, m_tgt;
   int        m_cnt;
   bit [NR-1:0] m_pwm;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq = '{0, 0};
         m_filt = 0; m_seen = 0; m_req = 0; m_ent = 0; m_ext = 0; m_tgt = 0;
         m_cnt = 0; m_pwm = '1;
      end else begin
         bit eff_both, eff_stby, eff_mode, masrt, sasrt, pw, rq, nreq, s2;
         masrt = m_seen && (m_filt != pol);
         sasrt = m_seen && (m_filt == pol);
         eff_mode = (func == 2'd0);
         eff_both = (func == 2'd2) && !slp;
         eff_stby = (func == 2'd1) || ((func == 2'd2) && slp);
         pw = mreg; rq = sreg;
         if (eff_mode) pw = mreg || masrt;
         if (eff_stby) rq = sreg || sasrt;
         if (eff_both) begin pw = mreg || !sasrt; rq = sreg || sasrt; end
         rq = rq && m_seen;
         nreq = (dev == 3'd4) ? m_req : rq;
         m_ent = nreq && !m_req;
         m_ext = !nreq && m_req;
         if (m_ent) m_tgt = slp;
         m_req = nreq;
         for (int i = 0; i < NR; i++) if (!ramp[i]) m_pwm[i] = pw;
         if (dev == 3'd2) m_seen = 1;
         s2 = sq[1];
         if (s2 != m_filt) begin
            m_cnt++;
            if (m_cnt == DG) begin m_filt = s2; m_cnt = 0; end
         end else m_cnt = 0;
         sq = '{pin, sq[0]};
      end
   end

   // Compare against the reference away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (pwm !== m_pwm || req !== m_req) begin
            errors++;
            $display("FAIL %s cycle %0d: pwm=%b req=%b expected pwm=%b req=%b",
                     tag, cycles, pwm, req, m_pwm, m_req);
         end
         checks++;
         if (ent !== m_ent || ext !== m_ext || tgt !== m_tgt) begin
            errors++;
            $display("FAIL R10 cycle %0d: enter=%b exit=%b tgt=%b expected %b %b %b",
                     cycles, ent, ext, tgt, m_ent, m_ext, m_tgt);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WD_MAX) begin
         errors++;
         $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_MAX);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_val(string t, logic [NR-1:0] act, logic [NR-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", t, act, exp);
      end
   endtask

   initial begin
      run(3);
      expect_val("R11 pwm", pwm, '1);
      expect_val("R11 flags", {1'b0, req, ent, ext} == 4'b0 ? 3'b0 : 3'b1, 3'b0);
      expect_val("R11 tgt", {2'b0, tgt}, 3'b0);
      rst_n = 1'b1;

      // R8: pin asserting standby and register request both ignored before ACTIVE
      tag = "R8";
      func = 2'd1; pol = 1'b0; pin = 1'b0;
      run(SETTLE);
      expect_val("R8 pin before active", {2'b0, req}, 3'b0);
      sreg = 1'b1; run(4);
      expect_val("R8 reg before active", {2'b0, req}, 3'b0);
      sreg = 1'b0;
      dev = 3'd2; run(3);
      expect_val("R8 honoured after active", {2'b0, req}, 3'b001);
      pin = 1'b1; run(SETTLE);
      expect_val("R4 pin high pol0 active", {2'b0, req}, 3'b0);

      // R2/R3: mode-only sweep
      tag = "R2";
      func = 2'd0;
      for (int p = 0; p < 2; p++)
         for (int l = 0; l < 2; l++)
            for (int m = 0; m < 2; m++) begin
               pol = p[0]; pin = l[0]; mreg = m[0];
               run(SETTLE);
               expect_val("R2 mode row", pwm, {NR{m[0] | (l[0] ^ p[0])}});
               expect_val("R3 no pin request", {2'b0, req}, 3'b0);
            end
      tag = "R3";
      sreg = 1'b1; run(3);
      expect_val("R3 register request", {2'b0, req}, 3'b001);
      sreg = 1'b0; run(3);

      // R1: glitch just shorter than the window, then a valid change
      tag = "R1";
      pol = 1'b0; mreg = 1'b0; pin = 1'b0; run(SETTLE);
      pin = 1'b1; run(DG - 2); pin = 1'b0; run(SETTLE);
      expect_val("R1 short pulse ignored", pwm, '0);
      pin = 1'b1; run(DG + 4);
      expect_val("R1 long pulse taken", pwm, '1);

      // R4: standby-only sweep
      tag = "R4";
      func = 2'd1;
      for (int p = 0; p < 2; p++)
         for (int l = 0; l < 2; l++)
            for (int s = 0; s < 2; s++)
               for (int m = 0; m < 2; m++) begin
                  pol = p[0]; pin = l[0]; sreg = s[0]; mreg = m[0];
                  run(SETTLE);
                  expect_val("R4 request", {2'b0, req}, {2'b0, s[0] | (l[0] == p[0])});
                  expect_val("R4 mode from register", pwm, {NR{m[0]}});
               end

      // R5/R6: combined sweep with STBY target, then with SLEEP target
      for (int q = 0; q < 2; q++) begin
         slp = q[0];
         tag = q ? "R6" : "R5";
         func = 2'd2;
         for (int p = 0; p < 2; p++)
            for (int l = 0; l < 2; l++)
               for (int s = 0; s < 2; s++)
                  for (int m = 0; m < 2; m++) begin
                     pol = p[0]; pin = l[0]; sreg = s[0]; mreg = m[0];
                     run(SETTLE);
                     expect_val(q ? "R6 request" : "R5 request", {2'b0, req},
                                {2'b0, s[0] | (l[0] == p[0])});
                     expect_val(q ? "R6 mode" : "R5 mode", pwm,
                                {NR{m[0] | (q == 0 && l[0] != p[0])}});
                  end
      end

      // R6: pin unused select
      tag = "R6"; slp = 1'b0; func = 2'd3; sreg = 1'b0; mreg = 1'b0;
      pol = 1'b0; pin = 1'b0; run(SETTLE);
      expect_val("R6 unused pin mode", pwm, '0);
      expect_val("R6 unused pin request", {2'b0, req}, 3'b0);

      // R7: one rail ramping during a mode change
      tag = "R7"; func = 2'd0; pol = 1'b0; pin = 1'b0; mreg = 1'b0; run(SETTLE);
      ramp = 3'b010; mreg = 1'b1; run(4);
      expect_val("R7 ramping rail held", pwm, 3'b101);
      ramp = '0; run(1);
      expect_val("R7 released rail", pwm, 3'b111);
      mreg = 1'b0; run(3);

      // R9/R10: enter with SLEEP target, freeze while in SLEEP
      tag = "R9"; func = 2'd1; pol = 1'b0; sreg = 1'b0; pin = 1'b1; run(SETTLE);
      slp = 1'b1; pin = 1'b0; run(SETTLE);
      expect_val("R10 sleep target captured", {1'b0, req, tgt}, 3'b011);
      dev = 3'd4; pin = 1'b1; run(SETTLE);
      expect_val("R9 request frozen in sleep", {2'b0, req}, 3'b001);
      dev = 3'd2; run(3);
      expect_val("R9 released after sleep", {2'b0, req}, 3'b0);
      run(4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule